// File: doc/BRIEF.md
# Ternary Instruction Fetch and Decode

This block walks a word-addressed program memory from address 0 and turns each balanced-ternary instruction into decoded fields for an execution stage. A word is nine trits. Each trit travels on two wires: `00` is 0, `01` is +1 and `10` is -1. Trit i of a word occupies bits [2i+1:2i], so trit 8 is the most significant.

Every instruction has the same layout. The four most significant trits (8..5) are the opcode. Trit 4 picks the addressing mode. Trits 3..2 are the first register selector. The meaning of trits 1..0 depends on the mode:

- In register-register mode (mode trit -1), trits 1..0 are a second register selector.
- In short-immediate mode (mode trit 0), trits 1..0 are a two-trit constant.
- In word-immediate mode (mode trit +1), trits 1..0 are a second register selector, and the instruction continues with one more full word that holds the constant.

The sequencer issues one read per word. It expects the read data one cycle after the read request. When an instruction is complete, it presents the fields for one cycle, together with the address of the instruction and the address of the one after it. Register selectors pass through as raw trit pairs. The pair `+0` names the return-address register and `++` names the stack pointer. Decoding those is left to the consumer.

Top module: `tern_fetch_decode`

## Requirements
- R1: While `rst` is high, `dec_valid` is low. The first read after `rst` falls goes to address 0.
- R2: `dec_opcode` is the signed value of instruction trits 8..5, with weights 27, 9, 3 and 1. `dec_mode` is the raw code of trit 4.
- R3: In register-register mode (mode code `10`), the instruction is one word long. `dec_rs1` is trits 3..2 and `dec_rs2` is trits 1..0. `dec_imm` is all zero trits. `dec_next_pc` is `dec_pc`+1.
- R4: In short-immediate mode (mode code `00`), the instruction is one word long. `dec_rs1` is trits 3..2 and `dec_rs2` is zero. `dec_imm` carries trits 1..0 in its two lowest trit positions and zero trits above them, which gives a value range of -4 to +4. `dec_next_pc` is `dec_pc`+1.
- R5: In word-immediate mode (mode code `01`), the word at `dec_pc`+1 is read. `dec_imm` is that word unchanged, which covers -9841 to +9841. Both selectors come from the first word. `dec_next_pc` is `dec_pc`+2.
- R6: `dec_valid` is high for exactly one cycle per instruction. The pulses are two cycles apart after a one-word instruction and three cycles apart after a two-word instruction.
- R7: `dec_illegal` rises together with `dec_valid` when the opcode is outside -39..-27, 0..4 and 30..37. This includes -40. It is never high without `dec_valid`. Fetching carries on in sequence.
- R8: The read issued in the cycle of a `dec_valid` pulse goes to `dec_next_pc`, so the program is fetched in order with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd_en | output | 1 | Read request to the program memory |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rdata | input | 18 | Word returned one cycle after the request |
| dec_valid | output | 1 | One-cycle strobe marking a decoded instruction |
| dec_opcode | output | 7 | Signed opcode value, -40 to +40 |
| dec_mode | output | 2 | Addressing-mode trit code |
| dec_rs1 | output | 4 | First register selector, two trits |
| dec_rs2 | output | 4 | Second register selector, zero in short mode |
| dec_imm | output | 18 | Immediate as a nine-trit word |
| dec_pc | output | ADDR_W | Address of the decoded instruction |
| dec_next_pc | output | ADDR_W | Address of the following instruction |
| dec_illegal | output | 1 | Opcode not in the legal set |

## Verification
A fault in the fetch state register or the address counter shows up at the ports within three cycles. Depending on the fault, the next `dec_valid` pulse arrives at the wrong spacing, the read that follows it misses `dec_next_pc`, or `dec_pc` stops counting in one- and two-word steps. A fault in field extraction appears in the first decoded instruction that uses the affected mode, because each mode is checked at its extreme constants. A fault in the legality table only shows when the bench reaches the affected opcode. For that reason the bench sweeps the edges of every legal range.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  localparam int WORD_TRITS = 9;
  localparam int WORD_W     = 2 * WORD_TRITS;
  localparam int OP_TRITS   = 4;
  localparam int OP_W       = 7;

  localparam logic [1:0] TRIT_Z = 2'b00;
  localparam logic [1:0] TRIT_P = 2'b01;
  localparam logic [1:0] TRIT_N = 2'b10;

  typedef enum logic [1:0] {SQ_FETCH, SQ_INSTR, SQ_IMM} seq_state_t;

  typedef struct packed {
    logic signed [OP_W-1:0] opcode;
    logic [1:0]             mode;
    logic [3:0]             rs1;
    logic [3:0]             rs2;
    logic [WORD_W-1:0]      imm;
    logic                   two_word;
  } dec_fields_t;

  function automatic int trit_val(input logic [1:0] t);
    if (t == TRIT_P) return 1;
    if (t == TRIT_N) return -1;
    return 0;
  endfunction

  function automatic logic signed [OP_W-1:0] op_value(input logic [2*OP_TRITS-1:0] f);
    int acc;
    int w;
    acc = 0;
    w = 1;
    for (int i = 0; i < OP_TRITS; i++) begin
      acc = acc + trit_val(f[2*i +: 2]) * w;
      w = w * 3;
    end
    return acc[OP_W-1:0];
  endfunction

  function automatic logic op_legal(input logic signed [OP_W-1:0] v);
    return (v >= -39 && v <= -27) || (v >= 0 && v <= 4) || (v >= 30 && v <= 37);
  endfunction

  function automatic logic mode_is_word(input logic [1:0] m);
    return m == TRIT_P;
  endfunction
endpackage

// File: rtl/tfd_sequencer.sv
module tfd_sequencer
  import tfd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] instr_q,
  output logic [WORD_W-1:0] imm_q,
  output logic [ADDR_W-1:0] ipc_q,
  output logic              valid_q,
  output logic              evt_instr,
  output logic              evt_imm
);
  seq_state_t        st_q;
  logic [ADDR_W-1:0] fpc_q;
  logic              word_now;

  assign word_now  = mode_is_word(rd_data[9:8]);
  assign evt_instr = (st_q == SQ_INSTR);
  assign evt_imm   = (st_q == SQ_IMM);

  always_comb begin
    rd_en   = (st_q == SQ_FETCH) || (evt_instr && word_now);
    rd_addr = (st_q == SQ_FETCH) ? fpc_q : fpc_q + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_FETCH;
      fpc_q   <= '0;
      ipc_q   <= '0;
      instr_q <= '0;
      imm_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st_q)
        SQ_FETCH: st_q <= SQ_INSTR;
        SQ_INSTR: begin
          instr_q <= rd_data;
          ipc_q   <= fpc_q;
          if (word_now) begin
            st_q <= SQ_IMM;
          end else begin
            fpc_q   <= fpc_q + ADDR_W'(1);
            valid_q <= 1'b1;
            st_q    <= SQ_FETCH;
          end
        end
        SQ_IMM: begin
          imm_q   <= rd_data;
          fpc_q   <= fpc_q + ADDR_W'(2);
          valid_q <= 1'b1;
          st_q    <= SQ_FETCH;
        end
        default: st_q <= SQ_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/tfd_field_split.sv
module tfd_field_split
  import tfd_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] imm_word,
  output dec_fields_t       fields
);
  logic [1:0] mode;
  assign mode = instr[9:8];

  always_comb begin
    fields.opcode   = op_value(instr[17:10]);
    fields.mode     = mode;
    fields.rs1      = instr[7:4];
    fields.two_word = mode_is_word(mode);
    if (mode == TRIT_N) begin
      fields.rs2 = instr[3:0];
      fields.imm = '0;
    end else if (mode == TRIT_P) begin
      fields.rs2 = instr[3:0];
      fields.imm = imm_word;
    end else begin
      fields.rs2 = '0;
      fields.imm = {{(WORD_W-4){1'b0}}, instr[3:0]};
    end
  end
endmodule

// File: rtl/tfd_opcode_check.sv
module tfd_opcode_check
  import tfd_pkg::*;
(
  input  logic signed [OP_W-1:0] opcode,
  input  logic                   valid,
  output logic                   illegal
);
  assign illegal = valid && !op_legal(opcode);
endmodule

// File: rtl/tern_fetch_decode.sv
module tern_fetch_decode
  import tfd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic                   mem_rd_en,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [WORD_W-1:0]      mem_rdata,
  output logic                   dec_valid,
  output logic signed [OP_W-1:0] dec_opcode,
  output logic [1:0]             dec_mode,
  output logic [3:0]             dec_rs1,
  output logic [3:0]             dec_rs2,
  output logic [WORD_W-1:0]      dec_imm,
  output logic [ADDR_W-1:0]      dec_pc,
  output logic [ADDR_W-1:0]      dec_next_pc,
  output logic                   dec_illegal
);
  logic [WORD_W-1:0] instr_q;
  logic [WORD_W-1:0] imm_q;
  logic              evt_instr;
  logic              evt_imm;
  dec_fields_t       fields;

  tfd_sequencer #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst(rst),
    .rd_en(mem_rd_en), .rd_addr(mem_addr), .rd_data(mem_rdata),
    .instr_q(instr_q), .imm_q(imm_q), .ipc_q(dec_pc), .valid_q(dec_valid),
    .evt_instr(evt_instr), .evt_imm(evt_imm)
  );

  tfd_field_split split_i (.instr(instr_q), .imm_word(imm_q), .fields(fields));

  tfd_opcode_check opchk_i (.opcode(fields.opcode), .valid(dec_valid), .illegal(dec_illegal));

  assign dec_opcode  = fields.opcode;
  assign dec_mode    = fields.mode;
  assign dec_rs1     = fields.rs1;
  assign dec_rs2     = fields.rs2;
  assign dec_imm     = fields.imm;
  assign dec_next_pc = dec_pc + (fields.two_word ? ADDR_W'(2) : ADDR_W'(1));
endmodule

// File: rtl/tfd_checker.sv
module tfd_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dec_valid,
  input logic [1:0]        dec_mode,
  input logic [3:0]        dec_rs2,
  input logic [17:0]       dec_imm,
  input logic [ADDR_W-1:0] dec_pc,
  input logic [ADDR_W-1:0] dec_next_pc,
  input logic              dec_illegal,
  input logic              evt_imm
);
  logic seen_rd;
  always_ff @(posedge clk) begin
    if (rst) seen_rd <= 1'b0;
    else if (mem_rd_en) seen_rd <= 1'b1;
  end

  assert_first_fetch_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !seen_rd) |-> mem_addr == '0);

  assert_one_word_len_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_mode != 2'b01) |-> dec_next_pc == dec_pc + ADDR_W'(1));

  assert_short_imm_range_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_mode == 2'b00) |-> (dec_imm[17:4] == '0 && dec_rs2 == '0));

  assert_word_imm_len_R5: assert property (@(posedge clk) disable iff (rst)
    evt_imm |=> (dec_valid && dec_next_pc == dec_pc + ADDR_W'(2)));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  assert_illegal_gated_R7: assert property (@(posedge clk) disable iff (rst)
    dec_illegal |-> dec_valid);

  assert_next_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (mem_rd_en && mem_addr == dec_next_pc));
endmodule

bind tern_fetch_decode tfd_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
  .dec_valid(dec_valid), .dec_mode(dec_mode), .dec_rs2(dec_rs2), .dec_imm(dec_imm),
  .dec_pc(dec_pc), .dec_next_pc(dec_next_pc), .dec_illegal(dec_illegal),
  .evt_imm(evt_imm)
);

// File: tb/tern_fetch_decode_tb_top.sv
module tern_fetch_decode_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [17:0] mem_rdata = '0;
  logic dec_valid;
  logic signed [6:0] dec_opcode;
  logic [1:0] dec_mode;
  logic [3:0] dec_rs1, dec_rs2;
  logic [17:0] dec_imm;
  logic [AW-1:0] dec_pc, dec_next_pc;
  logic dec_illegal;

  always #4 clk = ~clk;

  tern_fetch_decode #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dec_valid(dec_valid), .dec_opcode(dec_opcode), .dec_mode(dec_mode), .dec_rs1(dec_rs1),
    .dec_rs2(dec_rs2), .dec_imm(dec_imm), .dec_pc(dec_pc), .dec_next_pc(dec_next_pc),
    .dec_illegal(dec_illegal)
  );

  logic [17:0] mem [64];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[5:0]];

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int pulse_viol = 0;
  logic prev_valid = 1'b0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (!rst && dec_valid && prev_valid) pulse_viol++;
    prev_valid = dec_valid;
  end

  logic signed [6:0] c_op [16];
  logic [1:0] c_mode [16];
  logic [3:0] c_rs1 [16], c_rs2 [16];
  logic [17:0] c_imm [16];
  logic c_ill [16];
  int c_pc [16], c_npc [16], c_cyc [16];

  function automatic logic [17:0] enc(input int v, input int n);
    logic [17:0] w;
    int x;
    w = '0;
    x = v;
    for (int i = 0; i < n; i++) begin
      int r;
      r = ((x % 3) + 3) % 3;
      if (r == 1) begin w[2*i +: 2] = 2'b01; x = (x - 1) / 3; end
      else if (r == 2) begin w[2*i +: 2] = 2'b10; x = (x + 1) / 3; end
      else x = x / 3;
    end
    return w;
  endfunction

  function automatic logic [17:0] mk(input int op, input int mode, input int a, input int b);
    return (enc(op, 4) << 10) | (enc(mode, 1) << 8) | (enc(a, 2) << 4) | enc(b, 2);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = mk(0, -1, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(dec_valid == 1'b0, "R1", "valid in reset", dec_valid, 0);
    rst = 1'b0;
    #1;
    chk(mem_rd_en && mem_addr == 0, "R1", "first fetch addr", mem_addr, 0);
  endtask

  task automatic run_prog(input int n);
    do_reset();
    for (int k = 0; k < n; k++) begin
      int t;
      t = 0;
      @(negedge clk);
      while (!dec_valid && t < 50) begin @(negedge clk); t++; end
      chk(dec_valid == 1'b1, "R6", "decode timeout", 0, 1);
      c_op[k] = dec_opcode; c_mode[k] = dec_mode; c_rs1[k] = dec_rs1; c_rs2[k] = dec_rs2;
      c_imm[k] = dec_imm; c_ill[k] = dec_illegal; c_pc[k] = int'(dec_pc);
      c_npc[k] = int'(dec_next_pc); c_cyc[k] = cyc;
    end
  endtask

  task automatic test_reg_reg();
    clear_mem();
    mem[0] = mk(-39, -1, 3, -4);
    mem[1] = mk(2, -1, -2, 4);
    run_prog(2);
    chk(int'(c_op[0]) == -39, "R2", "opcode", c_op[0], -39);
    chk(c_mode[0] == 2'b10, "R2", "mode code", c_mode[0], 2);
    chk(c_rs1[0] == enc(3, 2) && c_rs2[0] == enc(-4, 2), "R3", "selectors",
        {c_rs1[0], c_rs2[0]}, {enc(3, 2)[3:0], enc(-4, 2)[3:0]});
    chk(c_imm[0] == 0, "R3", "imm zero", c_imm[0], 0);
    chk(c_pc[0] == 0 && c_npc[0] == 1, "R3", "next pc", c_npc[0], 1);
    chk(int'(c_op[1]) == 2 && c_rs1[1] == enc(-2, 2) && c_rs2[1] == enc(4, 2), "R3", "second instr",
        c_op[1], 2);
    chk(c_pc[1] == 1 && c_npc[1] == 2, "R8", "sequential pc", c_pc[1], 1);
  endtask

  task automatic test_short();
    clear_mem();
    mem[0] = mk(0, 0, 1, -4);
    mem[1] = mk(1, 0, -3, 4);
    mem[2] = mk(-28, 0, 4, 0);
    run_prog(3);
    chk(c_imm[0] == enc(-4, 9), "R4", "imm -4", c_imm[0], enc(-4, 9));
    chk(c_imm[1] == enc(4, 9), "R4", "imm +4", c_imm[1], enc(4, 9));
    chk(c_imm[2] == 0 && int'(c_op[2]) == -28, "R4", "imm 0 / op", c_imm[2], 0);
    chk(c_rs2[0] == 0 && c_rs2[1] == 0 && c_rs1[1] == enc(-3, 2), "R4", "selectors",
        c_rs2[1], 0);
    chk(c_npc[0] == 1 && c_npc[1] == 2 && c_npc[2] == 3, "R4", "next pc", c_npc[2], 3);
  endtask

  task automatic test_word();
    clear_mem();
    mem[0] = mk(0, 1, 4, 2);   mem[1] = enc(9841, 9);
    mem[2] = mk(36, 1, 0, 0);  mem[3] = enc(-9841, 9);
    mem[4] = mk(3, 1, -1, 1);  mem[5] = enc(-5, 9);
    mem[6] = mk(-39, -1, 0, 0);
    run_prog(4);
    chk(c_imm[0] == enc(9841, 9), "R5", "imm max", c_imm[0], enc(9841, 9));
    chk(c_imm[1] == enc(-9841, 9), "R5", "imm min", c_imm[1], enc(-9841, 9));
    chk(c_imm[2] == enc(-5, 9) && c_rs1[2] == enc(-1, 2) && c_rs2[2] == enc(1, 2), "R5",
        "imm and selectors", c_imm[2], enc(-5, 9));
    chk(c_pc[1] == 2 && c_pc[2] == 4 && c_pc[3] == 6, "R5", "instr addresses", c_pc[3], 6);
    chk(c_npc[0] == 2 && c_npc[2] == 6 && c_npc[3] == 7, "R8", "next pc", c_npc[3], 7);
    chk(int'(c_op[1]) == 36 && c_mode[1] == 2'b01, "R2", "opcode/mode", c_op[1], 36);
  endtask

  task automatic test_illegal();
    int ops [12] = '{-40, -39, -27, -26, 0, 4, 5, 29, 30, 37, 38, 40};
    bit bad [12] = '{1, 0, 0, 1, 0, 0, 1, 1, 0, 0, 1, 1};
    clear_mem();
    for (int i = 0; i < 12; i++) mem[i] = mk(ops[i], -1, 0, 0);
    run_prog(12);
    for (int i = 0; i < 12; i++) begin
      chk(c_ill[i] == bad[i], "R7", $sformatf("illegal flag op %0d", ops[i]), c_ill[i], bad[i]);
      chk(c_pc[i] == i && int'(c_op[i]) == ops[i], "R7", "continues in order", c_pc[i], i);
    end
  endtask

  task automatic test_timing();
    clear_mem();
    mem[0] = mk(0, -1, 0, 0);
    mem[1] = mk(0, 0, 0, 1);
    mem[2] = mk(0, 1, 0, 0); mem[3] = enc(7, 9);
    mem[4] = mk(0, -1, 0, 0);
    run_prog(4);
    chk(c_cyc[1] - c_cyc[0] == 2, "R6", "one-word spacing", c_cyc[1] - c_cyc[0], 2);
    chk(c_cyc[2] - c_cyc[1] == 3, "R6", "two-word spacing", c_cyc[2] - c_cyc[1], 3);
    chk(c_cyc[3] - c_cyc[2] == 2, "R6", "spacing after two-word", c_cyc[3] - c_cyc[2], 2);
    chk(pulse_viol == 0, "R6", "valid wider than one cycle", pulse_viol, 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", wd);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reg_reg();
    test_short();
    test_word();
    test_illegal();
    test_timing();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule